// File: doc/BRIEF.md
# Oversampled Serial Receive Engine

This block is the receive half of an asynchronous serial port. It watches a single serial input line, using a baud tick that pulses sixteen times per bit period, and it recovers words of either eight or nine data bits, sent least significant bit first between a low start bit and a high stop bit. Each finished word is moved from the internal shift register into a one-word holding buffer. A small set of sticky status flags reports a full buffer, an overrun, a bad stop bit (breaks included), noisy samples and an idle line. An interrupt request is built from those flags under two enables and one global mask input.

Software reaches the block over a simple register bus with a registered read port. The read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled. There are three registers. Address 0 is control: bit 0 enables the receiver, bit 1 selects nine-bit words, bit 2 enables the full interrupt, bit 3 enables the idle interrupt, and bit 7 is the read-only ninth received bit. Address 1 is the read-only status register: bit 0 buffer full, bit 1 overrun, bit 2 framing error, bit 3 noise, bit 4 idle. Address 2 is the read-only data buffer. Address 3 reads as zero. All flags are cleared by one handshake: a read of status, followed by a read of data.

Top module: `serial_rx_engine`

## Requirements
- R1: In eight-bit mode (control bit 1 clear), a frame with a low start bit, eight data bits sent least significant first and a high stop bit is delivered as that byte in the data register (address 2).
- R2: In nine-bit mode (control bit 1 set), the first eight data bits go to the data register and the ninth (most significant) bit appears in control bit 7. Control bit 7 reads 0 after an eight-bit word.
- R3: When a word completes while the buffer is empty, the word is loaded into the buffer and status bit 0 (full) is set.
- R4: The status flags are cleared only by a status read followed later by a data read. A data read with no status read before it returns the data and leaves the full flag set.
- R5: If a word completes while status bit 0 is still set, status bit 1 (overrun) is set, the buffered word is kept and the new word is discarded.
- R6: A frame whose stop bit samples low is stored and sets status bit 2 (framing error). An all-zero break counts as such a frame. After it, no new start bit is accepted until the line has been seen high.
- R7: Each bit is decided by a majority vote of samples 7, 8 and 9 out of sixteen. If any of those three disagree within a word, status bit 4 is not touched but status bit 3 (noise) is set, and the voted value is still used.
- R8: A falling edge whose start bit does not vote low at mid-bit is dropped as a false start and produces no word.
- R9: After a received frame, a high line lasting one full frame time (10 bit times in eight-bit mode, 11 in nine-bit mode, counted from the stop-bit decision) sets status bit 4 (idle) once. It is not set again until another frame is received.
- R10: The output `irq` is high in the cycle after (full and control bit 2) or (idle and control bit 3) holds while `irq_mask` is low. It is low in the cycle after `irq_mask` is high.
- R11: While control bit 0 is clear, the receiver does not search for start bits, so frames on the line produce no word and no flag.
- R12: After reset, control, status and data all read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial data input, idle high |
| baud_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| irq_mask | input | 1 | Global interrupt mask, high blocks `irq` |
| irq | output | 1 | Registered interrupt request |

## Verification
The main receive path is driven with a table of words: alternating bit patterns, all zeros and all ones in eight-bit mode, and nine-bit words with the top bit both set and clear. These separate bit-order errors, lost end bits and ninth-bit routing mistakes. Single-sample glitches inside the voting window show whether the vote masks the glitch while still raising noise. A short low pulse shows whether false starts are rejected. A break held past its stop bit shows whether framing errors are reported without producing a second, spurious word. Back-to-back words, lone data reads and long idle stretches test the overrun, clearing-handshake and one-shot idle rules.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_DRAIN
  } rx_state_t;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  localparam int CB_ON   = 0;
  localparam int CB_NINE = 1;
  localparam int CB_FIE  = 2;
  localparam int CB_IIE  = 3;
  localparam int CTRL_W  = 4;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       nine_mode,
  input  logic       tick,
  input  logic       line,
  output logic       done,
  output logic [8:0] word,
  output logic       ferr,
  output logic       noisy_o,
  output logic       idle_pulse
);

  localparam int CW    = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam int IDLE8 = 10 * OSR;
  localparam int IDLE9 = 11 * OSR;
  localparam int IW    = $clog2(IDLE9 + 1);

  localparam logic [CW-1:0] S_A    = CW'(MID - 1);
  localparam logic [CW-1:0] S_B    = CW'(MID);
  localparam logic [CW-1:0] S_C    = CW'(MID + 1);
  localparam logic [CW-1:0] S_EVAL = CW'(MID + 2);
  localparam logic [CW-1:0] S_LAST = CW'(OSR - 1);

  rx_state_t       st;
  logic [CW-1:0]   tcnt;
  logic [3:0]      bidx;
  logic [8:0]      shreg;
  logic [2:0]      samp;
  logic            noisy;
  logic            nine_q;
  logic [IW-1:0]   idle_cnt;
  logic            idle_armed;

  logic            vote;
  logic            split;
  logic [3:0]      last_bit;
  logic [IW-1:0]   idle_lim;

  always_comb begin
    vote     = (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
    split    = (samp != 3'b000) && (samp != 3'b111);
    last_bit = nine_q ? 4'd8 : 4'd7;
    idle_lim = nine_mode ? IW'(IDLE9 - 1) : IW'(IDLE8 - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_HUNT;
      tcnt       <= '0;
      bidx       <= '0;
      shreg      <= '0;
      samp       <= 3'b111;
      noisy      <= 1'b0;
      nine_q     <= 1'b0;
      idle_cnt   <= '0;
      idle_armed <= 1'b0;
      done       <= 1'b0;
      word       <= '0;
      ferr       <= 1'b0;
      noisy_o    <= 1'b0;
      idle_pulse <= 1'b0;
    end else begin
      done       <= 1'b0;
      idle_pulse <= 1'b0;
      if (!enable) begin
        st         <= ST_HUNT;
        tcnt       <= '0;
        idle_cnt   <= '0;
        idle_armed <= 1'b0;
      end else if (tick) begin
        if (st != ST_HUNT && st != ST_DRAIN) begin
          if (tcnt == S_A || tcnt == S_B || tcnt == S_C)
            samp <= {samp[1:0], line};
          tcnt <= (tcnt == S_LAST) ? '0 : tcnt + CW'(1);
        end
        unique case (st)
          ST_HUNT: begin
            if (!line) begin
              st       <= ST_START;
              tcnt     <= CW'(1);
              noisy    <= 1'b0;
              nine_q   <= nine_mode;
              idle_cnt <= '0;
            end else if (idle_armed) begin
              if (idle_cnt == idle_lim) begin
                idle_pulse <= 1'b1;
                idle_armed <= 1'b0;
                idle_cnt   <= '0;
              end else begin
                idle_cnt <= idle_cnt + IW'(1);
              end
            end
          end
          ST_START: begin
            if (tcnt == S_EVAL) begin
              if (vote) st <= ST_HUNT;
              noisy <= split;
            end else if (tcnt == S_LAST) begin
              st   <= ST_DATA;
              bidx <= '0;
            end
          end
          ST_DATA: begin
            if (tcnt == S_EVAL) begin
              shreg <= {vote, shreg[8:1]};
              noisy <= noisy | split;
            end else if (tcnt == S_LAST) begin
              if (bidx == last_bit) st <= ST_STOP;
              else                  bidx <= bidx + 4'd1;
            end
          end
          ST_STOP: begin
            if (tcnt == S_EVAL) begin
              done       <= 1'b1;
              word       <= nine_q ? shreg : {1'b0, shreg[8:1]};
              ferr       <= ~vote;
              noisy_o    <= noisy | split;
              idle_armed <= 1'b1;
              idle_cnt   <= '0;
              tcnt       <= '0;
              st         <= vote ? ST_HUNT : ST_DRAIN;
            end
          end
          ST_DRAIN: begin
            if (line) st <= ST_HUNT;
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  a_r11_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!done && !idle_pulse))
    else $error("R11: activity while receiver disabled");

  a_r6_drain_no_word: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DRAIN && enable) |=> !done)
    else $error("R6: word produced while waiting for high line");

endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank (
  input  logic       clk,
  input  logic       rst,
  input  logic       done,
  input  logic [8:0] word,
  input  logic       ferr,
  input  logic       noise,
  input  logic       idle_pulse,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  logic       full_ie,
  input  logic       idle_ie,
  input  logic       irq_mask,
  output logic [7:0] data_q,
  output logic       bit8_q,
  output logic       full,
  output logic       ovr,
  output logic       fe,
  output logic       nf,
  output logic       idle,
  output logic       irq
);

  logic armed;
  logic clear;
  logic store;
  logic ovr_set;

  always_comb begin
    clear   = data_rd & armed;
    store   = done & (~full | clear);
    ovr_set = done & full & ~clear;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      data_q <= '0;
      bit8_q <= 1'b0;
      full   <= 1'b0;
      ovr    <= 1'b0;
      fe     <= 1'b0;
      nf     <= 1'b0;
      idle   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (clear)        armed <= 1'b0;
      else if (stat_rd) armed <= 1'b1;
      if (clear) begin
        full <= 1'b0;
        ovr  <= 1'b0;
        fe   <= 1'b0;
        nf   <= 1'b0;
        idle <= 1'b0;
      end
      if (store) begin
        full   <= 1'b1;
        data_q <= word[7:0];
        bit8_q <= word[8];
        if (ferr)  fe <= 1'b1;
        if (noise) nf <= 1'b1;
      end
      if (ovr_set)    ovr  <= 1'b1;
      if (idle_pulse) idle <= 1'b1;
      irq <= ~irq_mask & ((full_ie & full) | (idle_ie & idle));
    end
  end

  a_r3_load_sets_full: assert property (@(posedge clk) disable iff (rst)
    (done && !full) |=> full)
    else $error("R3: full not set on completed word");

  a_r4_lone_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !armed && full) |=> full)
    else $error("R4: data read without status read cleared full");

  a_r5_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
    (done && full && !clear) |=> (ovr && $stable(data_q)))
    else $error("R5: overrun did not preserve buffer");

  a_r10_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq)
    else $error("R10: irq raised while masked");

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_line,
  input  logic       baud_tick,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_mask,
  output logic       irq
);

  logic [CTRL_W-1:0] ctrl_q;
  logic              line_s;
  logic              f_done;
  logic [8:0]        f_word;
  logic              f_ferr;
  logic              f_noise;
  logic              f_idle;
  logic [7:0]        data_q;
  logic              bit8_q;
  logic              full, ovr, fe, nf, idle;
  logic              stat_rd, data_rd;
  logic [7:0]        wdata_unused;

  assign wdata_unused = bus_wdata;
  assign stat_rd = bus_rd && (bus_addr == ADR_STAT);
  assign data_rd = bus_rd && (bus_addr == ADR_DATA);

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (line_s)
  );

  rx_framer #(.OSR(OSR)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .enable     (ctrl_q[CB_ON]),
    .nine_mode  (ctrl_q[CB_NINE]),
    .tick       (baud_tick),
    .line       (line_s),
    .done       (f_done),
    .word       (f_word),
    .ferr       (f_ferr),
    .noisy_o    (f_noise),
    .idle_pulse (f_idle)
  );

  rx_flag_bank u_flags (
    .clk        (clk),
    .rst        (rst),
    .done       (f_done),
    .word       (f_word),
    .ferr       (f_ferr),
    .noise      (f_noise),
    .idle_pulse (f_idle),
    .stat_rd    (stat_rd),
    .data_rd    (data_rd),
    .full_ie    (ctrl_q[CB_FIE]),
    .idle_ie    (ctrl_q[CB_IIE]),
    .irq_mask   (irq_mask),
    .data_q     (data_q),
    .bit8_q     (bit8_q),
    .full       (full),
    .ovr        (ovr),
    .fe         (fe),
    .nf         (nf),
    .idle       (idle),
    .irq        (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == ADR_CTRL)
        ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (bus_rd) begin
        unique case (bus_addr)
          ADR_CTRL: bus_rdata <= {bit8_q, {(7-CTRL_W){1'b0}}, ctrl_q};
          ADR_STAT: bus_rdata <= {3'b000, idle, nf, fe, ovr, full};
          ADR_DATA: bus_rdata <= data_q;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  a_r12_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_CTRL) |=> (ctrl_q == $past(bus_wdata[CTRL_W-1:0])))
    else $error("R12: control write not applied");

endmodule

// File: tb/serial_rx_engine_test.sv
module serial_rx_engine_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       baud_tick = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_mask = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [1:0] tdiv = 2'd0;

  serial_rx_engine uut (
    .clk       (clk),
    .rst       (rst),
    .rx_line   (rx_line),
    .baud_tick (baud_tick),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_mask  (irq_mask),
    .irq       (irq)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= tdiv + 2'd1;
    baud_tick <= (tdiv == 2'd3);
  end

  // fields: nine-bit mode [18], sent value [17:9], expected data [8:1], expected ninth bit [0]
  localparam logic [18:0] VEC [0:6] = '{
    {1'b0, 9'h055, 8'h55, 1'b0},
    {1'b1, 9'h1C6, 8'hC6, 1'b1},
    {1'b0, 9'h0A3, 8'hA3, 1'b0},
    {1'b1, 9'h0A5, 8'hA5, 1'b0},
    {1'b0, 9'h000, 8'h00, 1'b0},
    {1'b1, 9'h1FF, 8'hFF, 1'b1},
    {1'b0, 9'h0FF, 8'hFF, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic drive_bit(input logic b, input bit glitch);
    if (glitch) begin
      rx_line = b;  repeat (34) @(negedge clk);
      rx_line = ~b; repeat (4)  @(negedge clk);
      rx_line = b;  repeat (26) @(negedge clk);
    end else begin
      rx_line = b;  repeat (64) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [8:0] v, input bit nine,
                            input logic stop_v, input int glitch_bit);
    int nb;
    nb = nine ? 9 : 8;
    drive_bit(1'b0, glitch_bit == 0);
    for (int i = 0; i < nb; i++) drive_bit(v[i], glitch_bit == i + 1);
    drive_bit(stop_v, 1'b0);
    rx_line = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual unfinished, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R12 reset state
    bus_read(2'd0, rd); check("R12 control after reset", rd, 8'h00);
    bus_read(2'd1, rd); check("R12 status after reset", rd, 8'h00);
    bus_read(2'd2, rd); check("R12 data after reset", rd, 8'h00);
    check("R12 irq after reset", irq, 0);

    // R1 R2 R3 vector table
    for (int k = 0; k < 7; k++) begin
      bus_write(2'd0, {6'd0, VEC[k][18], 1'b1});
      send_frame(VEC[k][17:9], VEC[k][18], 1'b1, -1);
      bus_read(2'd1, rd); check("R3 full after word", rd, 8'h01);
      bus_read(2'd2, rd); check("R1 data byte", rd, VEC[k][8:1]);
      bus_read(2'd0, rd); check("R2 ninth bit", rd[7], VEC[k][0]);
    end

    // R4 lone data read does not clear
    bus_write(2'd0, 8'h01);
    send_frame(9'h03C, 0, 1'b1, -1);
    bus_read(2'd2, rd); check("R4 lone data read value", rd, 8'h3C);
    bus_read(2'd1, rd); check("R4 full kept after lone data read", rd, 8'h01);
    bus_read(2'd2, rd);
    bus_read(2'd1, rd); check("R4 cleared by status then data", rd, 8'h00);

    // R5 overrun
    send_frame(9'h011, 0, 1'b1, -1);
    send_frame(9'h022, 0, 1'b1, -1);
    bus_read(2'd1, rd); check("R5 overrun status", rd, 8'h03);
    bus_read(2'd2, rd); check("R5 first word kept", rd, 8'h11);
    bus_read(2'd1, rd); check("R5 flags cleared", rd, 8'h00);
    bus_read(2'd2, rd);

    // R7 noise glitch on data bit 3
    send_frame(9'h05A, 0, 1'b1, 4);
    bus_read(2'd1, rd); check("R7 noise flag", rd, 8'h09);
    bus_read(2'd2, rd); check("R7 voted data", rd, 8'h5A);

    // R8 false start
    rx_line = 1'b0; repeat (16) @(negedge clk); rx_line = 1'b1;
    repeat (200) @(negedge clk);
    bus_read(2'd1, rd); check("R8 false start ignored", rd, 8'h00);
    send_frame(9'h081, 0, 1'b1, -1);
    bus_read(2'd1, rd); check("R8 receiver recovers", rd, 8'h01);
    bus_read(2'd2, rd); check("R8 data after false start", rd, 8'h81);

    // R6 break held past stop bit
    send_frame(9'h000, 0, 1'b0, -1);
    rx_line = 1'b0; repeat (64) @(negedge clk); rx_line = 1'b1;
    repeat (20) @(negedge clk);
    bus_read(2'd1, rd); check("R6 break gives framing error", rd, 8'h05);
    bus_read(2'd2, rd); check("R6 break data", rd, 8'h00);
    send_frame(9'h042, 0, 1'b1, -1);
    bus_read(2'd1, rd); check("R6 clean word after break", rd, 8'h01);
    bus_read(2'd2, rd); check("R6 data after break", rd, 8'h42);

    // R9 idle detection, R10 idle interrupt
    send_frame(9'h033, 0, 1'b1, -1);
    bus_read(2'd1, rd);
    bus_read(2'd2, rd);
    repeat (500) @(negedge clk);
    bus_read(2'd1, rd); check("R9 idle not yet", rd, 8'h00);
    repeat (200) @(negedge clk);
    bus_read(2'd1, rd); check("R9 idle after frame time", rd, 8'h10);
    bus_write(2'd0, 8'h09);
    repeat (3) @(negedge clk);
    check("R10 idle irq", irq, 1);
    irq_mask = 1'b1; repeat (2) @(negedge clk);
    check("R10 mask blocks irq", irq, 0);
    irq_mask = 1'b0; repeat (2) @(negedge clk);
    bus_read(2'd2, rd);
    repeat (800) @(negedge clk);
    bus_read(2'd1, rd); check("R9 idle only once", rd, 8'h00);
    check("R10 irq low after clear", irq, 0);

    // R10 receive interrupt
    bus_write(2'd0, 8'h05);
    repeat (3) @(negedge clk);
    check("R10 no irq before word", irq, 0);
    send_frame(9'h077, 0, 1'b1, -1);
    check("R10 full irq", irq, 1);
    irq_mask = 1'b1; repeat (2) @(negedge clk);
    check("R10 full irq masked", irq, 0);
    irq_mask = 1'b0; repeat (2) @(negedge clk);
    check("R10 full irq unmasked", irq, 1);
    bus_read(2'd1, rd);
    bus_read(2'd2, rd); check("R10 data", rd, 8'h77);
    repeat (2) @(negedge clk);
    check("R10 irq drops after clear", irq, 0);

    // R11 receiver disabled
    bus_write(2'd0, 8'h00);
    send_frame(9'h099, 0, 1'b1, -1);
    repeat (20) @(negedge clk);
    bus_read(2'd1, rd); check("R11 disabled ignores frame", rd, 8'h00);
    bus_read(2'd2, rd); check("R11 data untouched", rd, 8'h77);
    bus_write(2'd0, 8'h01);
    send_frame(9'h066, 0, 1'b1, -1);
    bus_read(2'd1, rd); check("R11 enabled receives", rd, 8'h01);
    bus_read(2'd2, rd); check("R11 data after enable", rd, 8'h66);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule